// File: doc/BRIEF.md
# Selector Control Register Port over I2C

This block is a target on a two-wire serial bus with a 7-bit address. It gives a host microcontroller read and write access to a small register file that controls an input-port selector. A fast system clock samples the bus clock and data lines. From those samples the block detects start, repeated-start and stop conditions, and it acknowledges only its own device address.

A host writes in one transaction: the address byte with a write flag, a register pointer byte, then one or more data bytes. To read, the host first sets the pointer with a write phase. It then issues a repeated start with the read flag and clocks out data bytes. The pointer advances after every byte in both directions. A read continues for as long as the host acknowledges.

The control register holds two fields that are exported straight to the selector logic: a port-select field in its top two bits and an output edge-rate field. The pads are outside this block. The block only asks the pad to pull the data line low. It never stretches the clock.

Top module: `selreg_i2c_port`

## Requirements
- R1: After reset, `port_sel` is 2'b11 (first input), `edge_rate` is 2'b00, and `sda_pull` is 0.
- R2: The block acknowledges an address byte only when its upper seven bits equal 7'b0101100. Bit 0 of the address byte is the direction flag: 0 means write, 1 means read. After any other address, the block drives nothing until the next start condition.
- R3: In a write transaction, the byte after the address sets the register pointer (its low 3 bits). Each following byte is written to the register at the pointer and acknowledged. Register 0x01 is read/write: bits 7:6 drive `port_sel` and bits 5:4 drive `edge_rate`. Writing 8'h90 gives `port_sel` = 2'b10 (second input). The control register changes only through such a write.
- R4: The pointer advances by one after every data byte and wraps from 0x07 to 0x00.
- R5: A read that follows a repeated start with the read flag returns the register at the pointer, most significant bit first. The slave drives SDA only during bus-clock-low periods.
- R6: While the host acknowledges a read byte, the next register follows. After a not-acknowledge, the block releases SDA and stays released until the next start condition.
- R7: Register 0x00 reads the constant 8'h26 and register 0x02 reads the constant 8'h01. Registers 0x03 to 0x07 read 8'h00. Writes to all of these are acknowledged and have no effect.
- R8: A stop condition (SDA rising while SCL is high) returns the block to idle from any state. A partially received byte is dropped, and bus clocks that follow without a start are ignored.
- R9: The data-pull output changes only in response to a bus clock fall or a start/stop condition, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_in | input | 1 | Bus clock line level from the pad |
| sda_in | input | 1 | Bus data line level from the pad |
| sda_pull | output | 1 | Request to the pad to pull the data line low |
| port_sel | output | 2 | Port-select field for the selector (11 first, 10 second, 01 standby, 00 disallowed) |
| edge_rate | output | 2 | Output edge-rate setting for the selector |

## Verification
The bench builds the block with its default parameters: eight register slots, a 3-bit pointer and the fixed address. With eight slots, a three-byte burst starting at pointer 0x07 wraps the pointer and still lands on the control register, and a three-byte read walks a constant, the control register and a second constant. The bus is run with ten system clocks per quarter bit. That leaves enough margin for the three-stage sampling delay to fall well inside each clock-low window, so the tests of timing at start, stop and acknowledge are deterministic.

// File: rtl/selreg_pkg.sv
package selreg_pkg;

  localparam logic [6:0] DEV_ADDR  = 7'b0101100;
  localparam int         CTRL_ADDR = 1;
  localparam logic [7:0] ID_VALUE  = 8'h26;
  localparam logic [7:0] REV_VALUE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_WAIT
  } eng_state_e;

  typedef enum logic [1:0] {
    K_ADDR, K_PTR, K_DATA
  } rx_kind_e;

  function automatic bit reg_is_rw(input int a);
    return (a == CTRL_ADDR);
  endfunction

  function automatic logic [7:0] reg_reset(input int a);
    return (a == CTRL_ADDR) ? 8'hC0 : 8'h00;
  endfunction

  function automatic logic [7:0] reg_const(input int a);
    case (a)
      0:       return ID_VALUE;
      2:       return REV_VALUE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_pin_sampler.sv
module i2c_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_m, sda_m, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m   <= 1'b1;
      sda_m   <= 1'b1;
      scl_lvl <= 1'b1;
      sda_lvl <= 1'b1;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
    end else begin
      scl_m   <= scl_in;
      sda_m   <= sda_in;
      scl_lvl <= scl_m;
      sda_lvl <= sda_m;
      scl_d   <= scl_lvl;
      sda_d   <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  import selreg_pkg::*;

  eng_state_e       state, state_n;
  rx_kind_e         kind, kind_n;
  logic [3:0]       cnt, cnt_n;
  logic [7:0]       rx_sh, rx_sh_n;
  logic [7:0]       tx_sh, tx_sh_n;
  logic [PTR_W-1:0] ptr_n;
  logic             rw, rw_n;
  logic             ack_ok, ack_ok_n;

  always_comb begin
    state_n  = state;
    kind_n   = kind;
    cnt_n    = cnt;
    rx_sh_n  = rx_sh;
    tx_sh_n  = tx_sh;
    ptr_n    = ptr;
    rw_n     = rw;
    ack_ok_n = ack_ok;
    wr_en    = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
    end else if (start_det) begin
      state_n = ST_RX;
      kind_n  = K_ADDR;
      cnt_n   = 4'd0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            rx_sh_n = {rx_sh[6:0], sda_lvl};
            cnt_n   = cnt + 4'd1;
          end
          if (scl_fall && cnt == 4'd8) begin
            cnt_n = 4'd0;
            case (kind)
              K_ADDR: begin
                if (rx_sh[7:1] == DEV_ADDR) begin
                  state_n = ST_ACK;
                  rw_n    = rx_sh[0];
                end else begin
                  state_n = ST_WAIT;
                end
              end
              K_PTR: begin
                ptr_n   = rx_sh[PTR_W-1:0];
                state_n = ST_ACK;
              end
              default: begin
                wr_en   = 1'b1;
                ptr_n   = ptr + 1'b1;
                state_n = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = 4'd0;
            if (kind == K_ADDR && rw) begin
              state_n = ST_TX;
              tx_sh_n = rd_data;
            end else begin
              state_n = ST_RX;
              kind_n  = (kind == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              state_n = ST_TXACK;
              ptr_n   = ptr + 1'b1;
              cnt_n   = 4'd0;
            end else begin
              cnt_n   = cnt + 4'd1;
              tx_sh_n = {tx_sh[6:0], 1'b0};
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) ack_ok_n = ~sda_lvl;
          if (scl_fall) begin
            if (ack_ok) begin
              state_n = ST_TX;
              tx_sh_n = rd_data;
            end else begin
              state_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= K_ADDR;
      cnt    <= 4'd0;
      rx_sh  <= 8'h00;
      tx_sh  <= 8'hFF;
      ptr    <= '0;
      rw     <= 1'b0;
      ack_ok <= 1'b0;
    end else begin
      state  <= state_n;
      kind   <= kind_n;
      cnt    <= cnt_n;
      rx_sh  <= rx_sh_n;
      tx_sh  <= tx_sh_n;
      ptr    <= ptr_n;
      rw     <= rw_n;
      ack_ok <= ack_ok_n;
    end
  end

  assign wr_data  = rx_sh;
  assign sda_pull = (state == ST_ACK) || (state == ST_TX && !tx_sh[7]);

  // R9: slave-driven SDA never moves while SCL is held high
  p_sda_quiet_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
      |-> $stable(sda_pull));

  // R8: a stop always lands in idle with SDA released
  p_stop_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_pull);

  // R4: every accepted data byte advances the pointer by one
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R2: an acknowledge only follows a complete eighth bit
  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX && state_n == ST_ACK) |-> cnt == 4'd8);

endmodule

// File: rtl/selreg_regs.sv
module selreg_regs #(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic [7:0]       ctrl
);
  import selreg_pkg::*;

  logic [NUM_REGS-1:0][7:0] regs;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (reg_is_rw(g)) begin : g_rw
      logic [7:0] q;
      logic       hit;
      assign hit = wr_en && (wr_addr == PTR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= reg_reset(g);
        else if (hit) q <= wr_data;
      end
      assign regs[g] = q;
    end else begin : g_ro
      assign regs[g] = reg_const(g);
    end
  end

  assign rd_data = regs[rd_addr];
  assign ctrl    = regs[CTRL_ADDR];

  // R3: the control register holds unless a write strobe arrives
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl));

endmodule

// File: rtl/selreg_i2c_port.sv
module selreg_i2c_port #(
  parameter int NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [1:0] port_sel,
  output logic [1:0] edge_rate
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [7:0]       wr_data, rd_data, ctrl;

  i2c_pin_sampler u_smp (
    .clk(clk), .rst_n(rst_sync), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_sync), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_pull(sda_pull)
  );

  selreg_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_addr(ptr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data), .ctrl(ctrl)
  );

  assign port_sel  = ctrl[7:6];
  assign edge_rate = ctrl[5:4];

  // R1: freshly reset outputs hold the default selection
  p_reset_state_r1: assert property (@(posedge clk)
    (rst_sync && !$past(rst_sync)) |-> (port_sel == 2'b11 && edge_rate == 2'b00 && !sda_pull));

endmodule

// File: tb/selreg_i2c_port_test.sv
module selreg_i2c_port_test;

  localparam int Q = 10;
  localparam logic [7:0] AW = 8'h58;
  localparam logic [7:0] AR = 8'h59;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [1:0] port_sel, edge_rate;
  logic sda_line;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit ack_all;
  logic [7:0] rbuf [4];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  selreg_i2c_port uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .port_sel(port_sel), .edge_rate(edge_rate)
  );

  // ptr, written value, expected read-back
  localparam logic [23:0] VEC [7] = '{
    {8'h01, 8'h90, 8'h90},  // R3 second input
    {8'h01, 8'h7F, 8'h7F},  // R3 standby select
    {8'h00, 8'hFF, 8'h26},  // R7 id constant
    {8'h05, 8'hAB, 8'h00},  // R7 reserved
    {8'h06, 8'h55, 8'h00},  // R7 reserved
    {8'h02, 8'h33, 8'h01},  // R7 revision constant
    {8'h01, 8'hC0, 8'hC0}   // R3 back to first input
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(Q); scl = 1'b1; qwait(Q);
    sda_m = 1'b0; qwait(Q); scl = 1'b0; qwait(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(Q); scl = 1'b1; qwait(Q);
    sda_m = 1'b1; qwait(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait(Q); scl = 1'b1; qwait(2*Q); scl = 1'b0; qwait(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait(Q); scl = 1'b1; qwait(Q);
    b = sda_line; qwait(Q); scl = 1'b0; qwait(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic host_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~host_ack);
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d);
    logic a;
    ack_all = 1'b1;
    bus_start();
    send_byte(AW, a); ack_all &= a;
    send_byte(p, a);  ack_all &= a;
    send_byte(d, a);  ack_all &= a;
    bus_stop();
  endtask

  task automatic rd_regs(input logic [7:0] p, input int n);
    logic a;
    ack_all = 1'b1;
    bus_start();
    send_byte(AW, a); ack_all &= a;
    send_byte(p, a);  ack_all &= a;
    bus_start();
    send_byte(AR, a); ack_all &= a;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a, b;
    qwait(5);
    rst_n = 1'b1;
    qwait(5);
    // R1 reset state
    chk("R1 port_sel", {6'b0, port_sel}, 8'h03);
    chk("R1 edge_rate", {6'b0, edge_rate}, 8'h00);
    chk("R1 sda_pull", {7'b0, sda_pull}, 8'h00);

    for (int i = 0; i < 7; i++) begin
      wr_reg(VEC[i][23:16], VEC[i][15:8]);
      chk("R3/R7 write acks", {7'b0, ack_all}, 8'h01);
      rd_regs(VEC[i][23:16], 1);
      bus_stop();
      chk("R5 read acks", {7'b0, ack_all}, 8'h01);
      chk("R5/R7 read value", rbuf[0], VEC[i][7:0]);
      if (VEC[i][23:16] == 8'h01) begin
        chk("R3 port_sel", {6'b0, port_sel}, {6'b0, VEC[i][7:6]});
        chk("R3 edge_rate", {6'b0, edge_rate}, {6'b0, VEC[i][5:4]});
      end
    end
    chk("R7 ctrl untouched", {6'b0, port_sel}, 8'h03);

    // R2 foreign address: no ack, no write
    bus_start();
    send_byte(8'h5A, a);
    chk("R2 foreign addr nack", {7'b0, a}, 8'h00);
    send_byte(8'h01, a);
    send_byte(8'h10, a);
    chk("R2 foreign data nack", {7'b0, a}, 8'h00);
    bus_stop();
    chk("R2 ctrl unchanged", {6'b0, port_sel}, 8'h03);

    // R4 burst write from 0x07 wraps to 0x00 then 0x01
    ack_all = 1'b1;
    bus_start();
    send_byte(AW, a); ack_all &= a;
    send_byte(8'h07, a); ack_all &= a;
    send_byte(8'h11, a); ack_all &= a;
    send_byte(8'h22, a); ack_all &= a;
    send_byte(8'hA5, a); ack_all &= a;
    bus_stop();
    chk("R4 burst acks", {7'b0, ack_all}, 8'h01);
    chk("R4 wrap port_sel", {6'b0, port_sel}, 8'h02);
    chk("R4 wrap edge_rate", {6'b0, edge_rate}, 8'h02);

    // R6 burst read 0x00..0x02, then bus released after nack
    rd_regs(8'h00, 3);
    chk("R6 burst acks", {7'b0, ack_all}, 8'h01);
    chk("R6 byte0", rbuf[0], 8'h26);
    chk("R6 byte1", rbuf[1], 8'hA5);
    chk("R6 byte2", rbuf[2], 8'h01);
    recv_bit(b);
    chk("R6 released after nack", {7'b0, b}, 8'h01);
    bus_stop();

    // R8 stop mid-byte, then clocks without start are ignored
    bus_start();
    send_byte(AW, a);
    send_byte(8'h01, a);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    chk("R8 partial dropped", {6'b0, port_sel}, 8'h02);
    send_byte(8'h58, a);
    chk("R8 no ack without start", {7'b0, a}, 8'h00);
    send_byte(8'h00, a);
    chk("R8 ignored data nack", {7'b0, a}, 8'h00);
    chk("R8 ctrl kept", {6'b0, port_sel}, 8'h02);
    rd_regs(8'h01, 1);
    bus_stop();
    chk("R8 ctrl readback", rbuf[0], 8'hA5);

    // R9 read while pulling: bits of 0x00 keep SDA low across SCL high
    rd_regs(8'h05, 1);
    bus_stop();
    chk("R9 low byte stable", rbuf[0], 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule